// File: doc/BRIEF.md
# I2C Slave Single-Register Transfer Engine

This block is an I2C target that runs entirely on the system clock. SCL and SDA are first passed through synchronizers, and then sampled. The bus is driven through two open-drain enables: asserting an enable pulls that line low. After a start condition the engine shifts in a seven-bit address and a direction bit. It acknowledges only when the masked address matches its own.

The engine holds one data byte. When the master writes, each byte it sends is acknowledged and replaces that byte. A one-cycle strobe marks every arrival. When the master reads, the same byte is sent out again for every byte the master acknowledges.

A start or stop condition is recognised at any point in a transfer. The engine can add wait states: it holds SCL low between an acknowledge and the next byte of a write for as long as the local consumer asks.

Top module: `i2cs_engine`

## Requirements
- R1: While reset is high and on the first cycle after it, `scl_oe`, `sda_oe` and `rx_stb` are 0 and `data_q` is 0.
- R2: A start, followed by an address byte whose upper seven bits ANDed with ADDR_MASK (default 7'h7F) equal DEV_ADDR (default 7'h50) ANDed with the same mask, is acknowledged. The engine pulls SDA low during the ninth SCL high phase and releases it after the ninth SCL fall.
- R3: If the address does not match, SDA is never pulled low for that transfer, and a following byte leaves `data_q` unchanged.
- R4: In a write, each byte is taken MSB first from SDA samples on SCL high and is acknowledged. It then appears on `data_q`, and `rx_stb` pulses for exactly one cycle per byte. `data_q` never changes without `rx_stb`.
- R5: In a read, `data_q` is sent MSB first. A 1 bit leaves SDA released and a 0 bit pulls it low. SDA changes only while SCL is low, and it is released for the ninth clock.
- R6: In a read, a master ACK (SDA low at the ninth SCL high) makes the engine send the same byte again. A NACK makes it stop driving SDA until the next start.
- R7: A repeated start after written bytes returns the engine to address reception, so a read can follow in the same transfer.
- R8: After a stop the engine is idle. Clocked bits with no new start are neither acknowledged nor stored.
- R9: If `wait_req` is high at the SCL fall that ends an acknowledge of a write, `scl_oe` holds SCL low until `wait_req` drops. The transfer then continues normally.
- R10: `wait_req` has no effect outside that window. In particular, it never makes `scl_oe` assert during a read transfer.
- R11: The direction bit is the LSB of the address byte: 0 selects master write and 1 selects master read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 16 times the SCL rate |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Sensed SCL line level |
| sda_i | input | 1 | Sensed SDA line level |
| wait_req | input | 1 | Request to stretch SCL after a write acknowledge |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |
| data_q | output | 8 | The single data byte, written by the master and read back |
| rx_stb | output | 1 | One-cycle pulse when a byte has been written into `data_q` |

## Verification
A wrong control state shows at the ports within one SCL period. It appears as an acknowledge the master samples at the ninth clock, as an SDA pull where none belongs, or as a missing release before the following bit. A corrupted shift or sentinel shows on the next byte boundary: the wrong value lands on `data_q`, the strobe count drifts, or a read returns bits out of order. A mishandled repeated start or stop only shows on the transfer after it, so each scenario follows such a condition with traffic whose acknowledge and stored value are checked.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = BYTE_W - 1;
  localparam int SH_W   = BYTE_W + 1;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AMATCH,
    ST_ACK,
    ST_HOLD,
    ST_RX,
    ST_RXEND,
    ST_TX,
    ST_RACK,
    ST_TXNEXT,
    ST_WAITC
  } i2cs_state_t;
endpackage

// File: rtl/i2cs_sync.sv
module i2cs_sync #(
  parameter int              WIDTH   = 2,
  parameter int              STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) stg[s] <= RST_VAL;
    end else begin
      stg[0] <= d;
      for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/i2cs_cond.sv
module i2cs_cond (
  input  logic clk,
  input  logic rst,
  input  logic scl_s,
  input  logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_c,
  output logic stop_c
);
  logic scl_d, sda_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_s;
      sda_d <= sda_s;
    end
  end

  // SDA transitions count as conditions only while SCL stays high
  assign scl_rise = scl_s & ~scl_d;
  assign scl_fall = ~scl_s & scl_d;
  assign start_c  = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_c   = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/i2cs_ctrl.sv
module i2cs_ctrl
  import i2cs_pkg::*;
#(
  parameter logic [ADDR_W-1:0] DEV_ADDR  = 7'h50,
  parameter logic [ADDR_W-1:0] ADDR_MASK = 7'h7F
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_c,
  input  logic              stop_c,
  input  logic              wait_req,
  output logic              sda_oe,
  output logic              scl_oe,
  output logic [BYTE_W-1:0] data_q,
  output logic              rx_stb
);
  localparam logic [SH_W-1:0] SEED = SH_W'(1);
  localparam logic [SH_W-1:0] SENT = {1'b1, {BYTE_W{1'b0}}};

  i2cs_state_t     st;
  logic [SH_W-1:0] rsh, tsh;
  logic            dir_rd;
  logic [SH_W-1:0] rsh_nxt, tsh_nxt;
  logic            hit;

  assign rsh_nxt = {rsh[SH_W-2:0], sda_s};
  assign tsh_nxt = {tsh[SH_W-2:0], 1'b0};
  assign hit     = ((rsh[BYTE_W-1:1] & ADDR_MASK) == (DEV_ADDR & ADDR_MASK));

  always_ff @(posedge clk) begin
    rx_stb <= 1'b0;
    if (rst) begin
      st     <= ST_IDLE;
      rsh    <= '0;
      tsh    <= '0;
      dir_rd <= 1'b0;
      data_q <= '0;
      sda_oe <= 1'b0;
      scl_oe <= 1'b0;
    end else if (stop_c) begin
      st     <= ST_IDLE;
      sda_oe <= 1'b0;
      scl_oe <= 1'b0;
    end else if (start_c) begin
      st     <= ST_ADDR;
      rsh    <= SEED;
      sda_oe <= 1'b0;
      scl_oe <= 1'b0;
    end else begin
      unique case (st)
        ST_ADDR: if (scl_rise) begin
          rsh <= rsh_nxt;
          if (rsh_nxt[SH_W-1]) st <= ST_AMATCH;
        end
        ST_AMATCH: if (scl_fall) begin
          if (hit) begin
            sda_oe <= 1'b1;
            dir_rd <= rsh[0];
            st     <= ST_ACK;
          end else begin
            st <= ST_IDLE;
          end
        end
        ST_ACK: if (scl_fall) begin
          if (dir_rd) begin
            tsh    <= {data_q, 1'b1};
            sda_oe <= ~data_q[BYTE_W-1];
            st     <= ST_TX;
          end else begin
            sda_oe <= 1'b0;
            rsh    <= SEED;
            if (wait_req) begin
              scl_oe <= 1'b1;
              st     <= ST_HOLD;
            end else begin
              st <= ST_RX;
            end
          end
        end
        ST_HOLD: if (!wait_req) begin
          scl_oe <= 1'b0;
          st     <= ST_RX;
        end
        ST_RX: if (scl_rise) begin
          rsh <= rsh_nxt;
          if (rsh_nxt[SH_W-1]) begin
            data_q <= rsh_nxt[BYTE_W-1:0];
            rx_stb <= 1'b1;
            st     <= ST_RXEND;
          end
        end
        ST_RXEND: if (scl_fall) begin
          sda_oe <= 1'b1;
          st     <= ST_ACK;
        end
        ST_TX: if (scl_fall) begin
          if (tsh_nxt == SENT) begin
            sda_oe <= 1'b0;
            st     <= ST_RACK;
          end else begin
            tsh    <= tsh_nxt;
            sda_oe <= ~tsh_nxt[SH_W-1];
          end
        end
        ST_RACK: if (scl_rise) st <= sda_s ? ST_WAITC : ST_TXNEXT;
        ST_TXNEXT: if (scl_fall) begin
          tsh    <= {data_q, 1'b1};
          sda_oe <= ~data_q[BYTE_W-1];
          st     <= ST_TX;
        end
        ST_WAITC: if (scl_fall) st <= ST_IDLE;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/i2cs_engine.sv
module i2cs_engine
  import i2cs_pkg::*;
#(
  parameter logic [ADDR_W-1:0] DEV_ADDR    = 7'h50,
  parameter logic [ADDR_W-1:0] ADDR_MASK   = 7'h7F,
  parameter int                SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              wait_req,
  output logic              scl_oe,
  output logic              sda_oe,
  output logic [BYTE_W-1:0] data_q,
  output logic              rx_stb
);
  logic scl_s, sda_s;
  logic scl_rise, scl_fall, start_c, stop_c;

  i2cs_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({scl_i, sda_i}),
    .q   ({scl_s, sda_s})
  );

  i2cs_cond u_cond (
    .clk      (clk),
    .rst      (rst),
    .scl_s    (scl_s),
    .sda_s    (sda_s),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_c  (start_c),
    .stop_c   (stop_c)
  );

  i2cs_ctrl #(.DEV_ADDR(DEV_ADDR), .ADDR_MASK(ADDR_MASK)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .sda_s    (sda_s),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_c  (start_c),
    .stop_c   (stop_c),
    .wait_req (wait_req),
    .sda_oe   (sda_oe),
    .scl_oe   (scl_oe),
    .data_q   (data_q),
    .rx_stb   (rx_stb)
  );
endmodule

// File: rtl/i2cs_engine_chk.sv
module i2cs_engine_chk (
  input logic       clk,
  input logic       rst,
  input logic       scl_i,
  input logic       wait_req,
  input logic       sda_oe,
  input logic       scl_oe,
  input logic [7:0] data_q,
  input logic       rx_stb
);
  // R4: the strobe is a single-cycle pulse
  a_r4_stb_single: assert property (@(posedge clk) disable iff (rst)
    rx_stb |=> !rx_stb);

  // R4: the data byte is only replaced together with the strobe
  a_r4_data_with_stb: assert property (@(posedge clk) disable iff (rst)
    !$stable(data_q) |-> rx_stb);

  // R9: with no request pending, SCL is released by the next cycle
  a_r9_hold_needs_req: assert property (@(posedge clk) disable iff (rst)
    !wait_req |=> !scl_oe);

  // R9: stretching happens only while SDA is released
  a_r9_hold_sda_free: assert property (@(posedge clk) disable iff (rst)
    scl_oe |-> !sda_oe);

  // R5: the SDA drive moves only while the SCL line is low
  a_r5_sda_moves_scl_low: assert property (@(posedge clk) disable iff (rst)
    !$stable(sda_oe) |-> !scl_i);
endmodule

bind i2cs_engine i2cs_engine_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .scl_i    (scl_i),
  .wait_req (wait_req),
  .sda_oe   (sda_oe),
  .scl_oe   (scl_oe),
  .data_q   (data_q),
  .rx_stb   (rx_stb)
);

// File: tb/i2cs_engine_tb.sv
module i2cs_engine_tb;
  localparam int H = 20;
  localparam int Q = H / 2;
  localparam logic [6:0] ADDR = 7'h50;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic wait_req = 1'b0;
  logic scl_oe, sda_oe, rx_stb;
  logic [7:0] data_q;
  logic scl_line, sda_line;

  int total = 0, bad = 0;
  int cnt_stb = 0, cnt_sda = 0, cnt_scl = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  assign scl_line = scl_m & ~scl_oe;
  assign sda_line = sda_m & ~sda_oe;

  i2cs_engine u_dut (
    .clk      (clk),
    .rst      (rst),
    .scl_i    (scl_line),
    .sda_i    (sda_line),
    .wait_req (wait_req),
    .scl_oe   (scl_oe),
    .sda_oe   (sda_oe),
    .data_q   (data_q),
    .rx_stb   (rx_stb)
  );

  always @(posedge clk) begin
    if (rx_stb) cnt_stb++;
    if (sda_oe) cnt_sda++;
    if (scl_oe) cnt_scl++;
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; tick(H);
    sda_m = 1'b0; tick(H);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b1; tick(H);
    sda_m = 1'b1; tick(H);
  endtask

  task automatic clk_bit(input bit b, output bit s);
    sda_m = b; tick(Q);
    scl_m = 1'b1;
    do tick(1); while (!scl_line);
    tick(Q);
    s = sda_line;
    tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic wr_byte(input logic [7:0] b, output bit ack);
    bit s;
    for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
    clk_bit(1'b1, s);
    ack = !s;
  endtask

  task automatic rd_byte(input bit mack, output logic [7:0] b);
    bit s;
    for (int i = 7; i >= 0; i--) begin
      clk_bit(1'b1, s);
      b[i] = s;
    end
    clk_bit(!mack, s);
    sda_m = 1'b1;
  endtask

  task automatic t_reset();
    tick(1);
    chk(scl_oe == 0 && sda_oe == 0, "R1", "lines in reset", {scl_oe, sda_oe}, 0);
    chk(data_q == 0 && rx_stb == 0, "R1", "data in reset", data_q, 0);
    rst = 1'b0; tick(1);
    chk(scl_oe == 0 && sda_oe == 0 && rx_stb == 0, "R1", "after reset",
        {scl_oe, sda_oe, rx_stb}, 0);
  endtask

  task automatic t_write();
    bit ack; int s0;
    s0 = cnt_stb;
    bus_start();
    wr_byte({ADDR, 1'b0}, ack);
    chk(ack, "R2", "address ack", ack, 1);
    chk(sda_oe == 0, "R2", "ack released", sda_oe, 0);
    wr_byte(8'hA5, ack);
    chk(ack, "R4", "byte0 ack", ack, 1);
    chk(data_q == 8'hA5, "R11", "write dir stores", data_q, 8'hA5);
    wr_byte(8'h3C, ack);
    chk(ack && data_q == 8'h3C, "R4", "byte1 stored", data_q, 8'h3C);
    chk(cnt_stb - s0 == 2, "R4", "strobe count", cnt_stb - s0, 2);
    bus_stop();
  endtask

  task automatic t_read();
    bit ack, s; logic [7:0] b; int sd, sc, st;
    wait_req = 1'b1;
    sc = cnt_scl; st = cnt_stb;
    bus_start();
    wr_byte({ADDR, 1'b1}, ack);
    chk(ack, "R11", "read address ack", ack, 1);
    rd_byte(1'b1, b);
    chk(b == 8'h3C, "R5", "read byte0", b, 8'h3C);
    rd_byte(1'b0, b);
    chk(b == 8'h3C, "R6", "repeat after ack", b, 8'h3C);
    sd = cnt_sda;
    for (int i = 0; i < 9; i++) clk_bit(1'b1, s);
    chk(cnt_sda == sd, "R6", "no drive after nack", cnt_sda - sd, 0);
    bus_stop();
    chk(cnt_scl == sc, "R10", "no stretch in read", cnt_scl - sc, 0);
    chk(cnt_stb == st, "R4", "no strobe in read", cnt_stb - st, 0);
    wait_req = 1'b0;
  endtask

  task automatic t_rstart();
    bit ack; logic [7:0] b;
    bus_start();
    wr_byte({ADDR, 1'b0}, ack);
    wr_byte(8'h81, ack);
    chk(ack && data_q == 8'h81, "R7", "write before rstart", data_q, 8'h81);
    bus_start();
    wr_byte({ADDR, 1'b1}, ack);
    chk(ack, "R7", "address after rstart", ack, 1);
    rd_byte(1'b0, b);
    chk(b == 8'h81, "R7", "read after rstart", b, 8'h81);
    bus_stop();
  endtask

  task automatic t_miss();
    bit ack; int sd;
    sd = cnt_sda;
    bus_start();
    wr_byte({7'h51, 1'b0}, ack);
    chk(!ack, "R3", "mismatch no ack", ack, 0);
    wr_byte(8'h77, ack);
    chk(!ack && data_q == 8'h81, "R3", "mismatch data kept", data_q, 8'h81);
    chk(cnt_sda == sd, "R3", "sda never driven", cnt_sda - sd, 0);
    bus_stop();
  endtask

  task automatic t_stop();
    bit ack;
    bus_start();
    wr_byte({ADDR, 1'b0}, ack);
    wr_byte(8'h12, ack);
    bus_stop();
    wr_byte(8'h99, ack);
    chk(!ack, "R8", "idle after stop no ack", ack, 0);
    chk(data_q == 8'h12, "R8", "idle after stop data", data_q, 8'h12);
    bus_stop();
  endtask

  task automatic t_wait();
    bit ack;
    bus_start();
    wr_byte({ADDR, 1'b0}, ack);
    wait_req = 1'b1;
    wr_byte(8'h5A, ack);
    chk(ack && data_q == 8'h5A, "R9", "byte before hold", data_q, 8'h5A);
    chk(scl_oe == 1, "R9", "scl held", scl_oe, 1);
    tick(40);
    chk(scl_oe == 1, "R9", "scl still held", scl_oe, 1);
    wait_req = 1'b0;
    tick(4);
    chk(scl_oe == 0, "R9", "scl released", scl_oe, 0);
    wr_byte(8'hC3, ack);
    chk(ack && data_q == 8'hC3, "R9", "byte after hold", data_q, 8'hC3);
    bus_stop();
  endtask

  initial begin
    tick(3);
    t_reset();
    tick(5);
    t_write();
    t_read();
    t_rstart();
    t_miss();
    t_stop();
    t_wait();
    tick(10);
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++; bad++;
      $display("FAIL watchdog run hung actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule